// File: doc/BRIEF.md
# Read-First Write-Last Register Commit Unit

This block holds sixteen 16-bit data registers. It executes one combined instruction per cycle. Each instruction pairs an optional compute (add, subtract or pass) with an optional data move. The move is a register copy, a load from memory or a store to memory. All operands, including the value to be stored, are read from the register contents held before the instruction. The compute result and the moved data are both written at the end of the cycle. A register can therefore feed the compute and also be the target of a load or copy in the same instruction, and a store sends out the value the register had before the compute overwrote it.

The control decodes the descriptor and looks for illegal combinations. An illegal combination is either two writes aimed at one register, or register 14 used as both compute destination and move source. An illegal instruction raises the error flag and commits nothing: no register write, no flag update and no store. A copy from register 4 to register 4 that carries a compute is a status-only instruction: the flags update and no register changes. A combinational read port exposes any register.

Top module: `rf_commit`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, all sixteen registers read 0, the flags zero, negative and carry are 0, the error flag is 0 and the store strobe is 0.
- R2: Every operand is taken from the contents held before the instruction. A load or copy that overwrites a compute operand in the same instruction does not change the compute result. A copy whose source is the compute destination moves the old value.
- R3: A store (move code 3) drives the source register's pre-instruction value on the store data output, with the strobe high for the one cycle after the instruction. This holds even when the same instruction's compute overwrites that register.
- R4: Compute codes are 0 none, 1 X+Y, 2 X−Y and 3 pass X. The 16-bit result is written to the compute destination index at the end of the cycle.
- R5: The flags are zero (result is 0), negative (result bit 15) and carry. Carry is the add carry-out, 1 for a subtract with no borrow (X ≥ Y unsigned), and 0 for pass. The flags are registered and change only when an instruction carries a compute.
- R6: A load (move code 2) writes the memory data to the move destination. A copy (move code 1) writes the source register's old value to the move destination. Move code 0 moves nothing.
- R7: A compute together with a load or copy whose destination equals the compute destination sets the error flag and suppresses every register write, the flag update and the store.
- R8: A compute whose destination is register 14 together with a copy or store whose source is register 14 sets the error flag with the same suppression.
- R9: A compute together with a copy from register 4 to register 4 updates the flags from the result and writes no register. This instruction is never flagged as an error.
- R10: When the valid input is low, no register, flag or store output changes, and the error flag keeps the value set by the last valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Instruction present this cycle |
| opCompute | input | 2 | Compute code (0 none, 1 add, 2 sub, 3 pass) |
| opMove | input | 2 | Move code (0 none, 1 copy, 2 load, 3 store) |
| opSrcX | input | 4 | Compute X operand index |
| opSrcY | input | 4 | Compute Y operand index |
| opCmpDst | input | 4 | Compute destination index |
| opMvSrc | input | 4 | Copy or store source index |
| opMvDst | input | 4 | Copy or load destination index |
| loadData | input | 16 | Data returned by memory for a load |
| rdAddr | input | 4 | Read-port index |
| rdData | output | 16 | Current content of the register at rdAddr |
| storeData | output | 16 | Data sent to memory for a store |
| storeValid | output | 1 | Store data valid (one cycle) |
| flagZero | output | 1 | Zero flag |
| flagNeg | output | 1 | Negative flag |
| flagCarry | output | 1 | Carry flag |
| errFlag | output | 1 | Last valid instruction was illegal |

## Verification
An ordering fault, such as a write that lands before the read, shows as a wrong compute result or a wrong stored value. It is visible on the read port or the store output one cycle after the instruction. A decode fault in the collision or register-14 checks shows as a register that changed when it should not have, or as a missing error flag, also one cycle later. Flag faults persist until the next compute, so instructions without a compute are interleaved to expose flags that should have held. The vector sequence carries register state across instructions, so a wrong write committed early surfaces again in later probes.

// File: rtl/rf_commit_pkg.sv
package rf_commit_pkg;
  localparam int DATA_W = 16;
  localparam int NUM_REGS = 16;
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] RESULT_IDX = IDX_W'(4);
  localparam logic [IDX_W-1:0] SHARED_HI_IDX = IDX_W'(14);

  typedef enum logic [1:0] {
    CMP_NONE = 2'd0,
    CMP_ADD  = 2'd1,
    CMP_SUB  = 2'd2,
    CMP_PASS = 2'd3
  } cmp_e;

  typedef enum logic [1:0] {
    MV_NONE  = 2'd0,
    MV_COPY  = 2'd1,
    MV_LOAD  = 2'd2,
    MV_STORE = 2'd3
  } mv_e;

  typedef struct packed {
    logic issue;
    logic wrCompute;
    logic wrMove;
    logic selLoad;
    logic storeEn;
    logic updFlags;
    logic errNow;
  } ctrl_t;
endpackage

// File: rtl/rf_commit_ctrl.sv
module rf_commit_ctrl
  import rf_commit_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opValid,
  input  logic [1:0]    opCompute,
  input  logic [1:0]    opMove,
  input  logic [IW-1:0] opCmpDst,
  input  logic [IW-1:0] opMvSrc,
  input  logic [IW-1:0] opMvDst,
  output ctrl_t         strobes
);
  logic hasCompute;
  logic moveWrites;
  logic moveReads;
  logic statusOnly;
  logic destClash;
  logic sharedHiClash;
  logic illegal;

  always_comb begin
    hasCompute    = (opCompute != CMP_NONE);
    moveWrites    = (opMove == MV_COPY) || (opMove == MV_LOAD);
    moveReads     = (opMove == MV_COPY) || (opMove == MV_STORE);
    statusOnly    = hasCompute && (opMove == MV_COPY) &&
                    (opMvSrc == IW'(RESULT_IDX)) && (opMvDst == IW'(RESULT_IDX));
    destClash     = hasCompute && moveWrites && (opMvDst == opCmpDst) && !statusOnly;
    sharedHiClash = hasCompute && moveReads &&
                    (opCmpDst == IW'(SHARED_HI_IDX)) && (opMvSrc == IW'(SHARED_HI_IDX));
    illegal       = destClash || sharedHiClash;

    strobes.issue     = opValid;
    strobes.errNow    = opValid && illegal;
    strobes.wrCompute = opValid && !illegal && hasCompute && !statusOnly;
    strobes.wrMove    = opValid && !illegal && moveWrites && !statusOnly;
    strobes.selLoad   = (opMove == MV_LOAD);
    strobes.storeEn   = opValid && !illegal && (opMove == MV_STORE);
    strobes.updFlags  = opValid && !illegal && hasCompute;
  end

  // a store never also writes a register through the move path
  assert_store_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.storeEn |-> !strobes.wrMove);

  // an idle cycle raises no strobe
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |-> !(strobes.wrCompute || strobes.wrMove || strobes.storeEn || strobes.updFlags));
endmodule

// File: rtl/rf_commit_datapath.sv
module rf_commit_datapath
  import rf_commit_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGS,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         strobes,
  input  logic [1:0]    opCompute,
  input  logic [IW-1:0] opSrcX,
  input  logic [IW-1:0] opSrcY,
  input  logic [IW-1:0] opCmpDst,
  input  logic [IW-1:0] opMvSrc,
  input  logic [IW-1:0] opMvDst,
  input  logic [DW-1:0] loadData,
  input  logic [IW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] storeData,
  output logic          storeValid,
  output logic          flagZero,
  output logic          flagNeg,
  output logic          flagCarry,
  output logic          errFlag
);
  logic [NR-1:0][DW-1:0] regFile;
  logic [DW-1:0] xVal, yVal, mvSrcVal, mvVal, aluRes;
  logic [DW:0]   wideRes;
  logic          aluCarry;

  // operand sampling: every read sees pre-instruction contents
  always_comb begin
    xVal     = regFile[opSrcX];
    yVal     = regFile[opSrcY];
    mvSrcVal = regFile[opMvSrc];
    rdData   = regFile[rdAddr];
    mvVal    = strobes.selLoad ? loadData : mvSrcVal;
  end

  always_comb begin
    wideRes  = '0;
    aluCarry = 1'b0;
    unique case (opCompute)
      CMP_ADD: begin
        wideRes  = {1'b0, xVal} + {1'b0, yVal};
        aluCarry = wideRes[DW];
      end
      CMP_SUB: begin
        wideRes  = {1'b0, xVal} - {1'b0, yVal};
        aluCarry = !wideRes[DW];
      end
      CMP_PASS: wideRes = {1'b0, xVal};
      default:  wideRes = '0;
    endcase
    aluRes = wideRes[DW-1:0];
  end

  // end-of-cycle commit, one writer port per entry
  for (genvar g = 0; g < NR; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regFile[g] <= '0;
      end else if (strobes.wrMove && opMvDst == IW'(g)) begin
        regFile[g] <= mvVal;
      end else if (strobes.wrCompute && opCmpDst == IW'(g)) begin
        regFile[g] <= aluRes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagZero   <= 1'b0;
      flagNeg    <= 1'b0;
      flagCarry  <= 1'b0;
      errFlag    <= 1'b0;
      storeValid <= 1'b0;
      storeData  <= '0;
    end else begin
      storeValid <= strobes.storeEn;
      if (strobes.storeEn) storeData <= mvSrcVal;
      if (strobes.issue) errFlag <= strobes.errNow;
      if (strobes.updFlags) begin
        flagZero  <= (aluRes == '0);
        flagNeg   <= aluRes[DW-1];
        flagCarry <= aluCarry;
      end
    end
  end

  assert_err_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.errNow |=> $stable(regFile));

  assert_store_old_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.storeEn |=> (storeValid && storeData == $past(mvSrcVal)));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.updFlags |=> $stable({flagZero, flagNeg, flagCarry}));

  assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrCompute && strobes.wrMove) |-> (opCmpDst != opMvDst));
endmodule

// File: rtl/rf_commit.sv
module rf_commit
  import rf_commit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [1:0]        opCompute,
  input  logic [1:0]        opMove,
  input  logic [IDX_W-1:0]  opSrcX,
  input  logic [IDX_W-1:0]  opSrcY,
  input  logic [IDX_W-1:0]  opCmpDst,
  input  logic [IDX_W-1:0]  opMvSrc,
  input  logic [IDX_W-1:0]  opMvDst,
  input  logic [DATA_W-1:0] loadData,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] storeData,
  output logic              storeValid,
  output logic              flagZero,
  output logic              flagNeg,
  output logic              flagCarry,
  output logic              errFlag
);
  ctrl_t strobes;

  rf_commit_ctrl #(.IW(IDX_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCompute(opCompute),
    .opMove(opMove), .opCmpDst(opCmpDst), .opMvSrc(opMvSrc), .opMvDst(opMvDst),
    .strobes(strobes)
  );

  rf_commit_datapath #(.DW(DATA_W), .NR(NUM_REGS), .IW(IDX_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .opCompute(opCompute),
    .opSrcX(opSrcX), .opSrcY(opSrcY), .opCmpDst(opCmpDst), .opMvSrc(opMvSrc),
    .opMvDst(opMvDst), .loadData(loadData), .rdAddr(rdAddr), .rdData(rdData),
    .storeData(storeData), .storeValid(storeValid), .flagZero(flagZero),
    .flagNeg(flagNeg), .flagCarry(flagCarry), .errFlag(errFlag)
  );
endmodule

// File: tb/test_rf_commit.sv
module test_rf_commit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCompute = '0, opMove = '0;
  logic [3:0]  opSrcX = '0, opSrcY = '0, opCmpDst = '0, opMvSrc = '0, opMvDst = '0;
  logic [15:0] loadData = '0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData, storeData;
  logic        storeValid, flagZero, flagNeg, flagCarry, errFlag;

  int applied = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rf_commit i_rf_commit (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCompute(opCompute), .opMove(opMove),
    .opSrcX(opSrcX), .opSrcY(opSrcY), .opCmpDst(opCmpDst), .opMvSrc(opMvSrc),
    .opMvDst(opMvDst), .loadData(loadData), .rdAddr(rdAddr), .rdData(rdData),
    .storeData(storeData), .storeValid(storeValid), .flagZero(flagZero),
    .flagNeg(flagNeg), .flagCarry(flagCarry), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [1:0]  cmp;
    logic [1:0]  mv;
    logic [3:0]  x, y, d, ms, md;
    logic [15:0] ld;
    logic [3:0]  probe;
    logic [15:0] expProbe;
    logic [2:0]  expFlags;   // {zero, neg, carry}
    logic        expErr;
    logic        expSt;
    logic [15:0] expStData;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd2, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0005, 4'd0, 16'h0005, 3'b000, 1'b0, 1'b0, 16'h0000, 8'd6},  // R6 load
    '{2'd0, 2'd2, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2, 16'h0003, 4'd2, 16'h0003, 3'b000, 1'b0, 1'b0, 16'h0000, 8'd6},  // R6 load
    '{2'd1, 2'd2, 4'd0, 4'd2, 4'd4, 4'd0, 4'd0, 16'h0010, 4'd4, 16'h0008, 3'b000, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2 add uses old operand
    '{2'd2, 2'd3, 4'd0, 4'd2, 4'd4, 4'd4, 4'd0, 16'h0000, 4'd4, 16'h000D, 3'b001, 1'b0, 1'b1, 16'h0008, 8'd3},  // R3 store old, sub
    '{2'd3, 2'd1, 4'd4, 4'd0, 4'd5, 4'd5, 4'd6, 16'h0000, 4'd6, 16'h0000, 3'b000, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2 copy old value
    '{2'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0000, 4'd5, 16'h000D, 3'b000, 1'b0, 1'b0, 16'h0000, 8'd4},  // R4 pass result
    '{2'd2, 2'd0, 4'd2, 4'd0, 4'd7, 4'd0, 4'd0, 16'h0000, 4'd7, 16'hFFF3, 3'b010, 1'b0, 1'b0, 16'h0000, 8'd5},  // R5 borrow, negative
    '{2'd1, 2'd2, 4'd7, 4'd5, 4'd9, 4'd0, 4'd1, 16'hABCD, 4'd9, 16'h0000, 3'b101, 1'b0, 1'b0, 16'h0000, 8'd5},  // R5 zero + carry
    '{2'd1, 2'd2, 4'd0, 4'd0, 4'd3, 4'd0, 4'd3, 16'h1234, 4'd3, 16'h0000, 3'b101, 1'b1, 1'b0, 16'h0000, 8'd7},  // R7 load clash
    '{2'd2, 2'd1, 4'd0, 4'd2, 4'd4, 4'd4, 4'd4, 16'h0000, 4'd4, 16'h000D, 3'b001, 1'b0, 1'b0, 16'h0000, 8'd9},  // R9 status only
    '{2'd3, 2'd3, 4'd1, 4'd0, 4'd14, 4'd14, 4'd0, 16'h0000, 4'd14, 16'h0000, 3'b001, 1'b1, 1'b0, 16'h0000, 8'd8}, // R8 store reg 14
    '{2'd1, 2'd3, 4'd1, 4'd2, 4'd1, 4'd1, 4'd0, 16'h0000, 4'd1, 16'hABD0, 3'b010, 1'b0, 1'b1, 16'hABCD, 8'd3},  // R3 same reg
    '{2'd3, 2'd1, 4'd0, 4'd0, 4'd6, 4'd0, 4'd6, 16'h0000, 4'd6, 16'h0000, 3'b010, 1'b1, 1'b0, 16'h0000, 8'd7},  // R7 copy clash
    '{2'd3, 2'd1, 4'd0, 4'd0, 4'd14, 4'd14, 4'd2, 16'h0000, 4'd2, 16'h0003, 3'b010, 1'b1, 1'b0, 16'h0000, 8'd8}, // R8 copy reg 14
    '{2'd0, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0000, 4'd0, 16'h0010, 3'b010, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2 load landed
    '{2'd0, 2'd3, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 16'h0000, 4'd0, 16'h0010, 3'b010, 1'b0, 1'b1, 16'h0010, 8'd3}   // R3 store only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opCompute = v.cmp; opMove = v.mv; opSrcX = v.x; opSrcY = v.y;
    opCmpDst = v.d; opMvSrc = v.ms; opMvDst = v.md; loadData = v.ld;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    for (int i = 0; i < 16; i++) begin
      rdAddr = 4'(i); #1;
      check($sformatf("R1 reg %0d", i), 32'(rdData), 32'h0);
    end
    check("R1 flags/err/store", {flagZero, flagNeg, flagCarry, errFlag, storeValid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {flagZero, flagNeg, flagCarry, errFlag, storeValid}, 0);

    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k]);
      opValid = 1'b1;
      @(negedge clk);
      opValid = 1'b0;
      rdAddr = VECS[k].probe;
      #1;
      check($sformatf("R%0d v%0d probe", VECS[k].req, k), 32'(rdData), 32'(VECS[k].expProbe));
      check($sformatf("R%0d v%0d flags", VECS[k].req, k), {flagZero, flagNeg, flagCarry}, 32'(VECS[k].expFlags));
      check($sformatf("R%0d v%0d err", VECS[k].req, k), 32'(errFlag), 32'(VECS[k].expErr));
      check($sformatf("R%0d v%0d stValid", VECS[k].req, k), 32'(storeValid), 32'(VECS[k].expSt));
      if (VECS[k].expSt)
        check($sformatf("R%0d v%0d stData", VECS[k].req, k), 32'(storeData), 32'(VECS[k].expStData));
    end

    // R10: raise the error, then an invalid cycle with a live-looking descriptor
    opCompute = 2'd1; opMove = 2'd2; opSrcX = 4'd0; opSrcY = 4'd0;
    opCmpDst = 4'd8; opMvDst = 4'd8; loadData = 16'h7777;
    opValid = 1'b1;
    @(negedge clk);
    check("R7 clash err", 32'(errFlag), 32'h1);
    opValid = 1'b0;
    opCompute = 2'd1; opMove = 2'd3; opSrcX = 4'd0; opSrcY = 4'd0;
    opCmpDst = 4'd0; opMvSrc = 4'd0;
    @(negedge clk);
    rdAddr = 4'd0; #1;
    check("R10 reg0 held", 32'(rdData), 32'h0010);
    check("R10 flags held", {flagZero, flagNeg, flagCarry}, 32'b010);
    check("R10 err held", 32'(errFlag), 32'h1);
    check("R10 no store", 32'(storeValid), 32'h0);
    rdAddr = 4'd8; #1;
    check("R7 reg8 untouched", 32'(rdData), 32'h0);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rdAddr = 4'd1; #1;
    check("R1 mid reset reg1", 32'(rdData), 32'h0);
    check("R1 mid reset flags", {flagZero, flagNeg, flagCarry, errFlag}, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule